// File: doc/BRIEF.md
# Single-Port Synchronous SRAM Model

This block is a cycle-accurate, synthesizable model of a single-port synchronous RAM. The word count and word width are parameters. The address space can optionally be split across two banks, and that split changes nothing seen at the pins. The access type and address are taken on the rising clock edge. The low phase of the clock is an idle precharge phase.

The data-out bus drives only while three conditions hold together: the clock is high, chip select is asserted and output enable is asserted. At every other time it is released to high impedance. A separate drive-enable output tells the integrating logic when the bus carries a value. On a write, the bus carries the word just written.

Chip select, output enable and the address must not move while the clock is high. The model watches for such moves and raises a sticky error flag when it sees one. The chip-level logic uses this model wherever a compact on-chip scratch memory with this pin protocol is needed.

Top module: `sram_sp_top`

## Requirements
- R1: A rising clock edge with `cs_n` = 0 and `we_n` = 0 stores `din` at `addr`.
- R2: A rising clock edge with `cs_n` = 0 and `we_n` = 1 reads the word stored at `addr`. While the clock stays high, with `oe_n` = 0, `dout` shows that word and `dout_en` = 1.
- R3: With `cs_n` = 1 at a rising edge, no write takes place and the stored contents are kept. While the clock is high, `dout_en` = 0.
- R4: Whenever the clock is low, `dout_en` = 0 and `dout` is high impedance.
- R5: With `oe_n` = 1, `dout_en` = 0 even in the clock-high phase of an enabled read.
- R6: In the clock-high phase of a write, with `oe_n` = 0, `dout` shows the newly written `din` and not the old contents.
- R7: With `NUM_BANKS` = 2, the address MSB picks the bank, and only that bank is accessed. Two addresses that differ only in that bit hold independent words.
- R8: A change of `cs_n`, `oe_n` or `addr` during the clock-high phase sets `proto_err` at the next rising edge. The flag then stays set.
- R9: A rising edge with `rst_n` = 0 clears `proto_err`. Reset leaves the stored words untouched.
- R10: A change of `we_n` or `din` during the clock-high phase is not a protocol violation and leaves `proto_err` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge starts an access, low phase is precharge |
| rst_n | input | 1 | Synchronous active-low reset of the violation logic |
| cs_n | input | 1 | Chip select, active low; high means standby |
| we_n | input | 1 | 0 = write, 1 = read |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address, AW = clog2(WORDS) |
| din | input | DW | Write data |
| dout | output | DW | Tri-state read/write-through data |
| dout_en | output | 1 | 1 while `dout` is driven |
| proto_err | output | 1 | Sticky flag for control/address motion while clock is high |

## Verification
Two functions can meet in one clock period. The first is the data path: a write-through or a read drives the bus in the high phase. The second is the protocol monitor, which judges that same high phase. The bench provokes the overlap by moving `addr`, `cs_n` or `oe_n` in the middle of a driven high phase. It then expects the flag one edge later, and expects the flag to stay set until reset. In the contrasting case, it toggles `we_n` in the same phase of a read, expects the flag to stay clear, and expects the bus still to carry the value read.

// File: rtl/sram_sp_pkg.sv
// Package: shared helpers for the single-port SRAM model.
// Assumes: bank counts of 1 or 2.
package sram_sp_pkg;

    // Number of address bits used to pick a bank.
    function automatic int bank_sel_bits(input int nb);
        return (nb > 1) ? $clog2(nb) : 0;
    endfunction

    // Width of a vector that is never zero bits wide.
    function automatic int min_one(input int w);
        return (w > 0) ? w : 1;
    endfunction

endpackage

// File: rtl/sram_sp_bank.sv
// Module: one storage bank with a registered read/write-through word.
// Assumes: en and we are sampled at the rising edge; there is no reset on the array.
module sram_sp_bank #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int LAW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [LAW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Access on the rising edge: store and pass through, or fetch.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= din;
                rdata     <= din;
            end else begin
                rdata     <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/sram_sp_out.sv
// Module: output stage. It picks the bank word and decides the drive window.
// Assumes: cs_n and oe_n stay stable through the high phase.
module sram_sp_out #(
    parameter int NB    = 2,
    parameter int DW    = 8,
    parameter int SEL_W = 1
) (
    input  logic                clk,
    input  logic                acc,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NB-1:0][DW-1:0] bank_rd,
    input  logic                cs_n,
    input  logic                oe_n,
    output logic [DW-1:0]       word,
    output logic                drive
);

    logic [SEL_W-1:0] sel_q;

    // Remember which bank served the last access.
    always_ff @(posedge clk) begin
        if (acc) sel_q <= sel;
    end

    // Select the word of the bank that was accessed.
    always_comb begin
        word = bank_rd[0];
        for (int b = 1; b < NB; b++) begin
            if (sel_q == SEL_W'(b)) word = bank_rd[b];
        end
    end

    // The bus drives only in the high phase with chip and output enabled.
    assign drive = clk & ~cs_n & ~oe_n;

endmodule

// File: rtl/sram_sp_mon.sv
// Module: protocol monitor for motion on chip select, output enable or address in the high phase.
// Assumes: the inputs are free to move during the low phase; the reset is synchronous and active low.
module sram_sp_mon #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output logic          err
);

    localparam int SW = AW + 2;
    logic [SW-1:0] snap;
    logic          hi_chg;

    // Take the guarded inputs at the start of the high phase.
    always_ff @(posedge clk) begin
        snap <= {cs_n, oe_n, addr};
    end

    // Compare at the end of the high phase.
    always_ff @(negedge clk) begin
        if (!rst_n) hi_chg <= 1'b0;
        else        hi_chg <= (snap != {cs_n, oe_n, addr});
    end

    // Sticky flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      err <= 1'b0;
        else if (hi_chg) err <= 1'b1;
    end

endmodule

// File: rtl/sram_sp_top.sv
// Module: top of the single-port synchronous SRAM model.
// Assumes: NUM_BANKS is 1 or 2, and WORDS divides evenly among the banks.
module sram_sp_top
    import sram_sp_pkg::*;
#(
    parameter int WORDS     = 64,
    parameter int DW        = 8,
    parameter int NUM_BANKS = 2,
    localparam int AW       = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output wire  [DW-1:0] dout,
    output logic          dout_en,
    output logic          proto_err
);

    localparam int BSEL_W = bank_sel_bits(NUM_BANKS);
    localparam int SEL_W  = min_one(BSEL_W);
    localparam int DEPTH  = WORDS / NUM_BANKS;
    localparam int LAW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic                         acc;
    logic [SEL_W-1:0]             sel;
    logic [LAW-1:0]               laddr;
    logic [NUM_BANKS-1:0]         bank_en;
    logic [NUM_BANKS-1:0][DW-1:0] bank_rd;
    logic [DW-1:0]                rd_word;

    assign acc = ~cs_n;

    // Split the address into a bank select and a local word address.
    generate
        if (BSEL_W > 0) begin : g_split
            assign sel   = addr[AW-1 -: BSEL_W];
            assign laddr = addr[LAW-1:0];
        end else begin : g_flat
            assign sel   = '0;
            assign laddr = LAW'(addr);
        end
    endgenerate

    // One storage bank per instance; only the selected bank is enabled.
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_en[b] = acc & (sel == SEL_W'(b));
            sram_sp_bank #(.DEPTH(DEPTH), .DW(DW)) bank_i (
                .clk  (clk),
                .en   (bank_en[b]),
                .we   (~we_n),
                .addr (laddr),
                .din  (din),
                .rdata(bank_rd[b])
            );
        end
    endgenerate

    sram_sp_out #(.NB(NUM_BANKS), .DW(DW), .SEL_W(SEL_W)) out_i (
        .clk    (clk),
        .acc    (acc),
        .sel    (sel),
        .bank_rd(bank_rd),
        .cs_n   (cs_n),
        .oe_n   (oe_n),
        .word   (rd_word),
        .drive  (dout_en)
    );

    sram_sp_mon #(.AW(AW)) mon_i (
        .clk  (clk),
        .rst_n(rst_n),
        .cs_n (cs_n),
        .oe_n (oe_n),
        .addr (addr),
        .err  (proto_err)
    );

    // Turn the value and drive-enable pair into a tri-state bus.
    assign dout = dout_en ? rd_word : {DW{1'bz}};

    // R6: a write leaves the written word on the output path.
    assert_wr_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> (rd_word == $past(din)));

    // R3: in standby the output word is not disturbed.
    assert_standby_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(rd_word));

    // R7: at most one bank is active at each edge.
    assert_one_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en));

    // R3: no bank is enabled while chip select is high.
    assert_no_bank_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (bank_en == '0));

    // R8: the violation flag is sticky.
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R4: the bus is never driven in the low phase.
    always_comb begin
        if (rst_n && !clk) begin
            assert_hiz_low_R4: assert (!dout_en);
        end
    end

endmodule

// File: tb/sram_sp_top_tb_top.sv
`timescale 1ns/1ps
module sram_sp_top_tb_top;

    localparam int WORDS = 64;
    localparam int DW    = 8;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    wire  [DW-1:0] dout;
    logic          dout_en;
    logic          proto_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sram_sp_top #(.WORDS(WORDS), .DW(DW), .NUM_BANKS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .proto_err(proto_err)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One access: set inputs in the low phase, return 1 ns into the high phase.
    task automatic cyc(input bit c, input bit w, input bit o, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        #0.2;
        chk(dout_en == 1'b0, "R4 low phase", int'(dout_en), 0);
        #0.3;
        cs_n = c; we_n = w; oe_n = o; addr = AW'(a); din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        #0.5;
        rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #0.5;
        rst_n = 1'b1;
        #1;
        chk(proto_err == 1'b0, "R9 flag cleared", int'(proto_err), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        do_reset();
        chk(dout_en == 1'b0, "R3 idle after reset", int'(dout_en), 0);

        // R1 / R6: fill every word; the written word shows during the high phase.
        for (int a = 0; a < WORDS; a++) begin
            cyc(1'b0, 1'b0, 1'b0, a, pat(a));
            chk(dout_en == 1'b1, "R6 drive on write", int'(dout_en), 1);
            chk(dout == pat(a), "R6 write-through", int'(dout), int'(pat(a)));
        end

        // R2 / R1 / R7: read back every word; the upper and lower banks hold different data.
        for (int a = 0; a < WORDS; a++) begin
            cyc(1'b0, 1'b1, 1'b0, a, 8'h00);
            chk(dout_en == 1'b1, "R2 drive on read", int'(dout_en), 1);
            chk(dout == pat(a), "R2 R1 R7 read data", int'(dout), int'(pat(a)));
        end

        // R3: write attempts in standby change nothing and drive nothing.
        for (int a = 0; a < WORDS; a++) begin
            cyc(1'b1, 1'b0, 1'b0, a, ~pat(a));
            chk(dout_en == 1'b0, "R3 standby no drive", int'(dout_en), 0);
        end
        for (int a = 0; a < WORDS; a++) begin
            cyc(1'b0, 1'b1, 1'b0, a, 8'h00);
            chk(dout == pat(a), "R3 contents kept", int'(dout), int'(pat(a)));
        end

        // R5: output enable high suppresses the drive; the next enabled read shows the word.
        for (int a = 0; a < WORDS; a += 7) begin
            cyc(1'b0, 1'b1, 1'b1, a, 8'h00);
            chk(dout_en == 1'b0, "R5 oe high no drive", int'(dout_en), 0);
            cyc(1'b0, 1'b1, 1'b0, a, 8'h00);
            chk(dout == pat(a), "R5 data after oe", int'(dout), int'(pat(a)));
        end

        // R7: words that differ only in the bank bit are independent.
        cyc(1'b0, 1'b0, 1'b0, 3, 8'hA5);
        cyc(1'b0, 1'b0, 1'b0, 35, 8'h5A);
        cyc(1'b0, 1'b1, 1'b0, 3, 8'h00);
        chk(dout == 8'hA5, "R7 lower bank", int'(dout), 'hA5);
        cyc(1'b0, 1'b1, 1'b0, 35, 8'h00);
        chk(dout == 8'h5A, "R7 upper bank", int'(dout), 'h5A);
        chk(proto_err == 1'b0, "R8 no false flag", int'(proto_err), 0);

        // R10: moving we_n and din in the high phase is allowed.
        cyc(1'b0, 1'b1, 1'b0, 10, 8'h00);
        we_n = 1'b0; din = 8'hFF;
        cyc(1'b0, 1'b1, 1'b0, 10, 8'h00);
        chk(proto_err == 1'b0, "R10 we_n move ignored", int'(proto_err), 0);
        chk(dout == pat(10), "R10 no write", int'(dout), int'(pat(10)));

        // R8: address moves in the high phase of a driven read.
        cyc(1'b0, 1'b1, 1'b0, 12, 8'h00);
        chk(dout == pat(12), "R8 read before move", int'(dout), int'(pat(12)));
        addr = AW'(13);
        cyc(1'b0, 1'b1, 1'b0, 12, 8'h00);
        chk(proto_err == 1'b1, "R8 addr move flagged", int'(proto_err), 1);
        cyc(1'b1, 1'b1, 1'b1, 0, 8'h00);
        cyc(1'b1, 1'b1, 1'b1, 0, 8'h00);
        chk(proto_err == 1'b1, "R8 flag sticky", int'(proto_err), 1);
        do_reset();

        // R8: chip select moves in the high phase.
        cyc(1'b0, 1'b1, 1'b0, 20, 8'h00);
        cs_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, 20, 8'h00);
        chk(proto_err == 1'b1, "R8 cs move flagged", int'(proto_err), 1);
        do_reset();

        // R8: output enable moves in the high phase.
        cyc(1'b0, 1'b1, 1'b0, 21, 8'h00);
        oe_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, 21, 8'h00);
        chk(proto_err == 1'b1, "R8 oe move flagged", int'(proto_err), 1);
        do_reset();

        // R9: reset leaves the stored words intact.
        cyc(1'b0, 1'b1, 1'b0, 40, 8'h00);
        chk(dout == pat(40), "R9 contents survive reset", int'(dout), int'(pat(40)));
        chk(proto_err == 1'b0, "R9 flag stays clear", int'(proto_err), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule